// File: doc/BRIEF.md
# Audio Channel Status Capture and Insertion Controller

This block owns the 192-frame channel status block for eight embedded audio channels. The channels travel as four AES3 stereo pairs, and the block sees one subframe at a time. Each subframe arrives on a valid/ready stream with its channel index, a block-start flag that marks frame 0 of that channel's status block, and the incoming C bit. The block sends the subframe on through a one-entry output register, either with the C bit unchanged or with a substituted C bit. The host reaches the block through a synchronous byte register port.

There are two modes. In replace mode, a 184-bit status bank that the host programs supplies C-bit positions 0 to 183 of every outgoing block on every channel. Positions 184 to 191 carry an 8-bit CRC of that bank. In demultiplex mode, C bits pass through unchanged. In this mode the host can ask for one channel's status block. The block waits for that channel's next block start, copies bits 0 to 183 into the same bank, and raises a completion flag.

Stream rules: a subframe is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied that cycle. While `out_valid` is high and `out_ready` is low, the output holds its values. A sender may keep `in_valid` high for any length of time. The 128fs clocks of the two channel groups are expected to be brought to this block's single clock upstream.

Top module: `cs_status_ctrl`

## Requirements
- R1: After reset, the output register is empty, the control register at 0x6F reads 0x00, every status byte reads 0x00, and every channel's frame position is at 191, so a first subframe without block-start is frame 0.
- R2: Status bit 8k+j is bit j of the byte at address 0x58+k, for k from 0 to 22. These bytes read back what was last stored. Reads of any address other than 0x58 to 0x6F return 0x00.
- R3: The control register at 0x6F has this layout: bits 2..0 select the channel (0 means channel 1 and 7 means channel 8), bit 3 is the mode (1 = demultiplex, 0 = replace), bit 4 is the pending-request flag and bit 5 is the capture-complete flag. Bits 7..6 read 0.
- R4: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid`, `out_chan` and `out_cbit` stay unchanged.
- R5: In demultiplex mode, an accepted subframe appears on the next cycle with the same channel and C bit.
- R6: In replace mode, a subframe at frame position p < 184 leaves with status bit p as its C bit.
- R7: In replace mode, position 184+k (k from 0 to 7) carries bit k of a CRC-8 over status bits 0..183. The CRC is fed bit 0 first, with polynomial x^8+x^4+x^3+x^2+1 and initial value 0xFF.
- R8: The frame position of a channel is 0 on a subframe with block-start set. Otherwise it is that channel's previous position plus one, wrapping from 191 to 0.
- R9: A write to 0x6F with bits 4 and 3 both set, made while no capture is pending or running, sets the request flag, clears the complete flag and latches the selected channel. The request flag stays set until that channel's next block-start subframe is accepted, and clears on that edge.
- R10: A capture stores the latched channel's C bits from frames 0..183 of that block into status bits 0..183, in order. Other channels and frames 184..191 do not affect the bank. After frame 183, the complete flag goes high.
- R11: Host writes to 0x58..0x6E while a capture is pending or running leave the bank unchanged.
- R12: A write to 0x6F with bit 4 set and bit 3 clear updates the mode and the channel select but starts no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 8 | Host register address |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for `hst_addr`, combinational |
| in_valid | input | 1 | Input subframe valid |
| in_ready | output | 1 | Input subframe accepted this cycle when high with `in_valid` |
| in_chan | input | 3 | Channel index of the input subframe (0 means channel 1) |
| in_blk_start | input | 1 | Input subframe is frame 0 of its channel's block |
| in_cbit | input | 1 | Incoming C bit |
| out_valid | output | 1 | Output subframe valid |
| out_ready | input | 1 | Downstream takes the output subframe |
| out_chan | output | 3 | Channel index of the output subframe |
| out_cbit | output | 1 | C bit of the output subframe |

## Verification
The hardest state to reach is a capture that is pending or running while traffic is mixed. To get there, the request has to be issued while the selected channel is in the middle of a block. Subframes of a neighbouring channel must interleave, downstream must stall at random, and host writes must try to hit the bank before and during collection. The stimulus starts the selected channel at frame 100, so the request waits through the tail of one block before the real block begins. Host writes are issued in both the pending and the running phase, and a behavioural model follows the request, complete flag and bank contents on every clock.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned CS_NCH  = 8;
  localparam int unsigned CS_BLK  = 192;
  localparam int unsigned CS_BITS = 184;
  localparam logic [7:0]  CS_BASE = 8'h58;
  localparam logic [7:0]  CS_CTRL = 8'h6F;
  localparam logic [7:0]  CS_POLY = 8'h1D;
  localparam logic [7:0]  CS_SEED = 8'hFF;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_WAIT = 2'd1,
    CAP_RUN  = 2'd2
  } cap_state_e;

  // Serial CRC-8 over the status bits, bit 0 first.
  function automatic logic [7:0] crc8_block(input logic [CS_BITS-1:0] d);
    logic [7:0] r;
    logic       fb;
    r = CS_SEED;
    for (int i = 0; i < CS_BITS; i++) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ CS_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/cs_frame_track.sv
module cs_frame_track
  import cs_pkg::*;
#(
  parameter int unsigned NCH = CS_NCH,
  parameter int unsigned BLK = CS_BLK,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned PW  = $clog2(BLK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [CHW-1:0] ch,
  input  logic           bs,
  output logic [PW-1:0]  pos
);
  logic [PW-1:0] last [NCH];
  logic [PW-1:0] cur;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [PW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                       cnt_q <= PW'(BLK - 1);
      else if (adv && ch == CHW'(g))    cnt_q <= pos;
    end
    assign last[g] = cnt_q;
  end

  always_comb begin
    cur = last[ch];
    if (bs)                         pos = '0;
    else if (cur == PW'(BLK - 1))   pos = '0;
    else                            pos = cur + 1'b1;
  end

  // R8: a position never leaves the block
  a_r8_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pos < PW'(BLK));
endmodule

// File: rtl/cs_capture.sv
module cs_capture
  import cs_pkg::*;
#(
  parameter int unsigned NCH  = CS_NCH,
  parameter int unsigned BITS = CS_BITS,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned IW  = $clog2(BITS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [CHW-1:0] req_ch,
  input  logic           adv,
  input  logic [CHW-1:0] ch,
  input  logic           bs,
  input  logic           cbit,
  output logic           busy,
  output logic           waiting,
  output logic           start,
  output logic           done,
  output logic           we,
  output logic [IW-1:0]  widx,
  output logic           wbit
);
  cap_state_e     state;
  logic [CHW-1:0] cap_ch;
  logic [IW-1:0]  nidx;
  logic           hit;

  always_comb begin
    hit     = adv && (ch == cap_ch);
    busy    = (state != CAP_IDLE);
    waiting = (state == CAP_WAIT);
    start   = waiting && hit && bs;
    we      = start || (state == CAP_RUN && hit);
    widx    = start ? '0 : nidx;
    wbit    = cbit;
    done    = (state == CAP_RUN) && hit && (nidx == IW'(BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= CAP_IDLE;
      cap_ch <= '0;
      nidx   <= '0;
    end else begin
      unique case (state)
        CAP_IDLE: if (req) begin
          state  <= CAP_WAIT;
          cap_ch <= req_ch;
        end
        CAP_WAIT: if (start) begin
          state <= CAP_RUN;
          nidx  <= IW'(1);
        end
        CAP_RUN: if (hit) begin
          if (done) state <= CAP_IDLE;
          else      nidx  <= nidx + 1'b1;
        end
        default: state <= CAP_IDLE;
      endcase
    end
  end

  // R9: collection begins in the cycle after the block start is seen
  a_r9_run_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == CAP_RUN));
  // R10: the index only moves forward while running
  a_r10_index_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAP_RUN && hit && !done) |=> (nidx == $past(nidx) + 1'b1));
endmodule

// File: rtl/cs_host_regs.sv
module cs_host_regs
  import cs_pkg::*;
#(
  parameter int unsigned NCH  = CS_NCH,
  parameter int unsigned BITS = CS_BITS,
  localparam int unsigned CHW    = $clog2(NCH),
  localparam int unsigned IW     = $clog2(BITS),
  localparam int unsigned NBYTES = BITS / 8,
  localparam int unsigned OW     = $clog2(NBYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      addr,
  input  logic            wr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic            cap_busy,
  input  logic            cap_start,
  input  logic            cap_done,
  input  logic            cap_we,
  input  logic [IW-1:0]   cap_idx,
  input  logic            cap_bit,
  output logic [BITS-1:0] bank,
  output logic            mode,
  output logic [CHW-1:0]  sel,
  output logic            req,
  output logic            rqst,
  output logic            wend
);
  logic          bank_hit;
  logic          ctrl_hit;
  logic [7:0]    off_full;
  logic [OW-1:0] boff;

  always_comb begin
    bank_hit = (addr >= CS_BASE) && (addr < CS_BASE + 8'(NBYTES));
    ctrl_hit = (addr == CS_CTRL);
    off_full = addr - CS_BASE;
    boff     = off_full[OW-1:0];
    req      = wr && ctrl_hit && wdata[4] && wdata[3] && !cap_busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank <= '0;
    end else begin
      if (wr && bank_hit && !cap_busy) bank[{boff, 3'b000} +: 8] <= wdata;
      if (cap_we)                      bank[cap_idx] <= cap_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= '0;
      mode <= 1'b0;
      rqst <= 1'b0;
      wend <= 1'b0;
    end else begin
      if (wr && ctrl_hit) begin
        sel  <= wdata[CHW-1:0];
        mode <= wdata[3];
      end
      if (req)            rqst <= 1'b1;
      else if (cap_start) rqst <= 1'b0;
      if (req)            wend <= 1'b0;
      else if (cap_done)  wend <= 1'b1;
    end
  end

  always_comb begin
    if (bank_hit)      rdata = bank[{boff, 3'b000} +: 8];
    else if (ctrl_hit) rdata = 8'({wend, rqst, mode, sel});
    else               rdata = 8'h00;
  end

  // R11: the bank is frozen against host writes while capture owns it
  a_r11_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bank_hit && cap_busy && !cap_we) |=> $stable(bank));
  // R12: a request without demultiplex mode does not start capture
  a_r12_need_demux: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ctrl_hit && wdata[4] && !wdata[3] && !rqst) |=> !rqst);
endmodule

// File: rtl/cs_status_ctrl.sv
module cs_status_ctrl
  import cs_pkg::*;
#(
  parameter int unsigned NCH  = CS_NCH,
  parameter int unsigned BLK  = CS_BLK,
  parameter int unsigned BITS = CS_BITS,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned PW  = $clog2(BLK),
  localparam int unsigned IW  = $clog2(BITS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     hst_addr,
  input  logic           hst_wr,
  input  logic [7:0]     hst_wdata,
  output logic [7:0]     hst_rdata,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CHW-1:0] in_chan,
  input  logic           in_blk_start,
  input  logic           in_cbit,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CHW-1:0] out_chan,
  output logic           out_cbit
);
  logic            adv;
  logic [PW-1:0]   pos;
  logic [BITS-1:0] bank;
  logic            mode, req, rqst, wend;
  logic [CHW-1:0]  sel;
  logic            cap_busy, cap_waiting, cap_start, cap_done, cap_we, cap_bit;
  logic [IW-1:0]   cap_idx;
  logic [7:0]      crc;
  logic            nxt_cbit;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  cs_frame_track #(.NCH(NCH), .BLK(BLK)) u_track (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ch(in_chan), .bs(in_blk_start), .pos(pos)
  );

  cs_capture #(.NCH(NCH), .BITS(BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .req(req), .req_ch(hst_wdata[CHW-1:0]),
    .adv(adv), .ch(in_chan), .bs(in_blk_start), .cbit(in_cbit),
    .busy(cap_busy), .waiting(cap_waiting), .start(cap_start), .done(cap_done),
    .we(cap_we), .widx(cap_idx), .wbit(cap_bit)
  );

  cs_host_regs #(.NCH(NCH), .BITS(BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(hst_addr), .wr(hst_wr), .wdata(hst_wdata),
    .rdata(hst_rdata), .cap_busy(cap_busy), .cap_start(cap_start),
    .cap_done(cap_done), .cap_we(cap_we), .cap_idx(cap_idx), .cap_bit(cap_bit),
    .bank(bank), .mode(mode), .sel(sel), .req(req), .rqst(rqst), .wend(wend)
  );

  always_comb begin
    crc = crc8_block(bank);
    if (mode)                    nxt_cbit = in_cbit;
    else if (pos < PW'(BITS))    nxt_cbit = bank[pos];
    else                         nxt_cbit = crc[pos[2:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_cbit  <= 1'b0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_chan  <= in_chan;
      out_cbit  <= nxt_cbit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R4: a stalled output holds
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_cbit)));
  // R9: the request flag mirrors a pending capture
  a_r9_rqst_tracks_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rqst == cap_waiting);
  // R10: completion only comes out of an active capture
  a_r10_wend_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wend) |-> $past(cap_busy));
endmodule

// File: tb/sim_cs_status_ctrl.sv
module sim_cs_status_ctrl;
  logic       clk, rst_n;
  logic [7:0] hst_addr, hst_wdata, hst_rdata;
  logic       hst_wr;
  logic       in_valid, in_ready, in_blk_start, in_cbit;
  logic [2:0] in_chan, out_chan;
  logic       out_valid, out_ready, out_cbit;

  cs_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_chan(in_chan), .in_blk_start(in_blk_start),
    .in_cbit(in_cbit), .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan), .out_cbit(out_cbit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit stall_en = 0;
  bit done_flag = 0;

  // behavioural reference state
  bit mbank [184];
  int mmode = 0, msel = 0, mrqst = 0, mwend = 0;
  int mcap = 0, mcch = 0, mcnt = 0;
  int lastpos [8];
  int qc[$], qch[$];
  string qt[$];
  bit pat [192];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mcrc();
    int r = 8'hFF;
    for (int i = 0; i < 184; i++) begin
      int top = (r >> 7) & 1;
      r = (r << 1) & 8'hFF;
      if ((top ^ int'(mbank[i])) != 0) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  function automatic int mrd(int a);
    int v = 0;
    if (a >= 8'h58 && a <= 8'h6E) begin
      for (int j = 0; j < 8; j++) v |= int'(mbank[(a - 8'h58) * 8 + j]) << j;
      return v;
    end
    if (a == 8'h6F) return (mwend << 5) | (mrqst << 4) | (mmode << 3) | msel;
    return 0;
  endfunction

  task automatic step();
    int e, p, busy_pre;
    string t;
    e = mrd(int'(hst_addr));
    chk(int'(hst_rdata) == e, (hst_addr == 8'h6F) ? "R3 ctrl read" : "R2 byte read",
        int'(hst_rdata), e);
    chk(in_ready == (!out_valid || out_ready), "R4 ready rule", int'(in_ready),
        int'(!out_valid || out_ready));
    chk(out_valid == (qc.size() > 0), "R4 valid", int'(out_valid), int'(qc.size() > 0));
    if (out_valid && qc.size() > 0) begin
      chk(int'(out_cbit) == qc[0] && int'(out_chan) == qch[0], qt[0],
          int'({out_chan, out_cbit}), (qch[0] << 1) | qc[0]);
      if (out_ready) begin
        void'(qc.pop_front()); void'(qch.pop_front()); void'(qt.pop_front());
      end
    end
    busy_pre = (mcap != 0);
    if (in_valid && in_ready) begin
      p = in_blk_start ? 0 : (lastpos[in_chan] == 191 ? 0 : lastpos[in_chan] + 1);
      lastpos[in_chan] = p;
      if (mmode != 0) begin e = int'(in_cbit); t = "R5 passthrough"; end
      else if (p < 184) begin e = int'(mbank[p]); t = "R6 R8 replaced bit"; end
      else begin e = (mcrc() >> (p - 184)) & 1; t = "R7 R8 crc bit"; end
      qc.push_back(e); qch.push_back(int'(in_chan)); qt.push_back(t);
      if (mcap == 1 && int'(in_chan) == mcch && in_blk_start) begin
        mbank[0] = in_cbit; mcap = 2; mcnt = 1; mrqst = 0;
      end else if (mcap == 2 && int'(in_chan) == mcch) begin
        mbank[mcnt] = in_cbit;
        if (mcnt == 183) begin mcap = 0; mwend = 1; end
        else mcnt++;
      end
    end
    if (hst_wr) begin
      if (hst_addr >= 8'h58 && hst_addr <= 8'h6E && busy_pre == 0)
        for (int j = 0; j < 8; j++) mbank[(int'(hst_addr) - 8'h58) * 8 + j] = hst_wdata[j];
      if (hst_addr == 8'h6F) begin
        msel = int'(hst_wdata[2:0]); mmode = int'(hst_wdata[3]);
        if (hst_wdata[4] && hst_wdata[3] && busy_pre == 0) begin
          mrqst = 1; mwend = 0; mcap = 1; mcch = int'(hst_wdata[2:0]);
        end
      end
    end
  endtask

  always begin
    @(negedge clk);
    #4;
    if (rst_n && !done_flag) step();
  end

  always @(negedge clk) out_ready <= stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;

  task automatic hwrite(int a, int d);
    hst_addr = 8'(a); hst_wdata = 8'(d); hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    hst_addr = 8'(a);
    #1;
    chk(int'(hst_rdata) == exp, tag, int'(hst_rdata), exp);
    @(negedge clk);
  endtask

  task automatic send(int ch, int c, int bs);
    in_valid = 1'b1; in_chan = 3'(ch); in_cbit = c[0]; in_blk_start = bs[0];
    forever begin
      #4;
      if (in_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog: stream never drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int exp;
    for (int i = 0; i < 184; i++) mbank[i] = 0;
    for (int i = 0; i < 8; i++) lastpos[i] = 191;
    for (int f = 0; f < 192; f++) pat[f] = bit'(((f * 7) ^ (f >> 2)) & 1);
    rst_n = 0; hst_addr = 0; hst_wdata = 0; hst_wr = 0;
    in_valid = 0; in_chan = 0; in_blk_start = 0; in_cbit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h6F, 0, "R1 ctrl after reset");
    rd(8'h58, 0, "R1 bank after reset");
    chk(out_valid == 1'b0, "R1 output empty", int'(out_valid), 0);
    // R2 program and read bank, unmapped reads
    for (int k = 0; k < 23; k++) hwrite(8'h58 + k, (k * 37 + 5) & 8'hFF);
    rd(8'h5A, (2 * 37 + 5) & 8'hFF, "R2 bank byte readback");
    rd(8'h57, 0, "R2 unmapped below");
    rd(8'h70, 0, "R2 unmapped above");
    // R6 R7 R8 replace mode, two channels, with stalls
    stall_en = 1;
    for (int f = 0; f < 192; f++)
      for (int c = 0; c < 2; c++) send(c, $urandom_range(0, 1), f == 0);
    // R8 reset position and wrap without block start
    for (int n = 0; n < 200; n++) send(6, 0, 0);
    // R5 demultiplex passthrough
    hwrite(8'h6F, 8'h0A);
    for (int n = 0; n < 60; n++)
      send($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1));
    // R12 request without demultiplex mode
    hwrite(8'h6F, 8'h15);
    rd(8'h6F, 8'h05, "R12 no capture in replace mode");
    // R9 capture request
    hwrite(8'h6F, 8'h1D);
    rd(8'h6F, 8'h1D, "R9 request pending");
    hwrite(8'h58, 8'hAA);
    rd(8'h58, 5, "R11 write ignored while pending");
    for (int f = 100; f < 192; f++) begin
      send(4, $urandom_range(0, 1), 0);
      send(5, $urandom_range(0, 1), 0);
    end
    rd(8'h6F, 8'h1D, "R9 still pending before block start");
    for (int f = 0; f < 192; f++) begin
      send(4, $urandom_range(0, 1), f == 0);
      send(5, int'(pat[f]), f == 0);
      if (f == 0) rd(8'h6F, 8'h0D, "R9 request cleared at block start");
      if (f == 9) begin
        hwrite(8'h60, 8'h55);
        rd(8'h60, (8 * 37 + 5) & 8'hFF, "R11 write ignored while running");
      end
    end
    rd(8'h6F, 8'h2D, "R10 complete flag set");
    for (int k = 0; k < 23; k++) begin
      exp = 0;
      for (int j = 0; j < 8; j++) exp |= int'(pat[k * 8 + j]) << j;
      rd(8'h58 + k, exp, "R10 captured byte");
    end
    // R6 R7 replace with captured data on all channels
    hwrite(8'h6F, 8'h05);
    rd(8'h6F, 8'h25, "R3 complete flag kept in replace");
    for (int f = 0; f < 192; f++)
      for (int c = 0; c < 8; c++) send(c, $urandom_range(0, 1), f == 0);
    // R9 a new request clears the complete flag
    hwrite(8'h6F, 8'h18);
    rd(8'h6F, 8'h18, "R9 new request clears complete");
    stall_en = 0;
    repeat (4) @(negedge clk);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule